// File: doc/BRIEF.md
# Half-Bridge Drain-Source Short Fault Monitor

This block watches the two digital outputs of the drain-source overvoltage comparators that guard one half-bridge. The low-side comparator reveals a load shorted to the supply rail. The high-side comparator reveals a load shorted to ground. The block takes four inputs: the two comparator levels, the two gate commands, a stop-on-fault configuration bit and a mask bit. From these it produces three results for each side: a one-clock detection pulse for a status register, a latched fault state, and a gate-disable request.

Each comparator level first passes through a synchronizer. A side's comparator is examined only while that side's gate command is on. An internal down-counting blanking timer suppresses both comparators after every rising edge of either gate command. A qualified fault latches. What clears it depends on the stop-on-fault bit:

- With the bit off, only the faulted side is disabled, and its latch clears when that side is next commanded on.
- With the bit on, both sides are disabled until reset.

Top module: `ds_short_monitor`

## Requirements
- R1: A high low-side comparator level seen while the low-side gate command is on and not blanked sets the low-side latched fault and raises the low-side disable request.
- R2: A high high-side comparator level seen while the high-side gate command is on and not blanked sets the high-side latched fault and raises the high-side disable request.
- R3: After a rising edge of either gate command is sampled at clock edge E1, a comparator cannot set a fault at edges E1 to E(BLANK_CYCLES+1). The first edge that can set a fault is E(BLANK_CYCLES+2).
- R4: With stop-on-fault at 1, a latched fault on either side raises both disable requests. The latch then holds through any later gate commands until reset.
- R5: With stop-on-fault at 0, only the faulted side's disable request is raised. That side's latch and disable request clear at the first clock edge that samples a rising edge of that side's gate command.
- R6: While the mask bit is 1, no fault latches, no pulse is produced and no disable request is raised.
- R7: Synchronous active-high reset clears all latched faults, pulses and disable requests to 0.
- R8: A comparator rise on a side whose gate has been on for longer than the blanking window appears on the latch, pulse and disable outputs at the third clock edge. The pulse lasts exactly one clock per latched fault, even if the comparator stays high.
- R9: A comparator level is ignored while its own side's gate command is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (system or power-on) |
| cmp_hs_i | input | 1 | High-side drain-source comparator, asynchronous, 1 = overvoltage |
| cmp_ls_i | input | 1 | Low-side drain-source comparator, asynchronous, 1 = overvoltage |
| gate_hs_i | input | 1 | High-side gate command, 1 = on |
| gate_ls_i | input | 1 | Low-side gate command, 1 = on |
| stop_on_fault_i | input | 1 | 1 = any fault disables both sides and holds until reset |
| mask_i | input | 1 | 1 = diagnostic disabled |
| flt_pulse_hs_o | output | 1 | One-clock high-side detection pulse |
| flt_pulse_ls_o | output | 1 | One-clock low-side detection pulse |
| flt_hs_o | output | 1 | High-side latched fault state |
| flt_ls_o | output | 1 | Low-side latched fault state |
| off_hs_o | output | 1 | High-side gate-disable request |
| off_ls_o | output | 1 | Low-side gate-disable request |

## Verification
A comparator change reaches the outputs three edges after it is applied: two synchronizer flops, then the fault register. The bench therefore samples no earlier than the negative edge after that third edge.

A gate rise restarts blanking at the first edge that samples it. The bench checks the latch at the negative edge after E(BLANK_CYCLES+1), where it must still be 0, and again after E(BLANK_CYCLES+2), where it must be 1.

A clear caused by a re-command is registered at the edge that samples the rise, so it is checked half a cycle later. The table-driven runs hold each pattern well past these windows and count pulses over the whole hold.

// File: rtl/ds_mon_pkg.sv
package ds_mon_pkg;
  localparam int NSIDE = 2;
  typedef enum logic [0:0] { SIDE_HS = 1'b0, SIDE_LS = 1'b1 } side_e;
endpackage

// File: rtl/ds_sync.sv
module ds_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/ds_blank_timer.sv
module ds_blank_timer #(
  parameter int NSIDE        = 2,
  parameter int BLANK_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSIDE-1:0] gate_i,
  output logic [NSIDE-1:0] rise_o,
  output logic             blank_o
);
  localparam int CW = $clog2(BLANK_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BLANK_CYCLES);

  logic [NSIDE-1:0] gate_d;
  logic [CW-1:0]    cnt;

  assign rise_o  = gate_i & ~gate_d;
  assign blank_o = (cnt != '0) || (|rise_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_d <= '0;
      cnt    <= '0;
    end else begin
      gate_d <= gate_i;
      if (|rise_o)        cnt <= LOAD;
      else if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= LOAD);
  p_rise_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (|rise_o) |=> (cnt == LOAD));
endmodule

// File: rtl/ds_side_qual.sv
module ds_side_qual (
  input  logic clk,
  input  logic rst,
  input  logic cmp_s_i,
  input  logic gate_i,
  input  logic rise_i,
  input  logic blank_i,
  input  logic mask_i,
  input  logic sof_i,
  output logic lat_next_o,
  output logic lat_o,
  output logic pulse_o
);
  logic qual;
  logic clr;

  assign qual = cmp_s_i & gate_i & ~blank_i & ~mask_i;
  assign clr  = rise_i & ~sof_i;

  always_comb begin
    lat_next_o = lat_o;
    if (qual)     lat_next_o = 1'b1;
    else if (clr) lat_next_o = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_o   <= 1'b0;
      pulse_o <= 1'b0;
    end else begin
      lat_o   <= lat_next_o;
      pulse_o <= qual & ~lat_o;
    end
  end

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
  p_pulse_has_latch_r8: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> lat_o);
  p_latch_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (lat_o && !(rise_i && !sof_i)) |=> lat_o);
  p_blank_no_set_r3: assert property (@(posedge clk) disable iff (rst)
    (!lat_o && blank_i) |=> !lat_o);
  p_gate_off_no_set_r9: assert property (@(posedge clk) disable iff (rst)
    (!lat_o && !gate_i) |=> !lat_o);
endmodule

// File: rtl/ds_short_monitor.sv
module ds_short_monitor #(
  parameter int BLANK_CYCLES = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmp_hs_i,
  input  logic cmp_ls_i,
  input  logic gate_hs_i,
  input  logic gate_ls_i,
  input  logic stop_on_fault_i,
  input  logic mask_i,
  output logic flt_pulse_hs_o,
  output logic flt_pulse_ls_o,
  output logic flt_hs_o,
  output logic flt_ls_o,
  output logic off_hs_o,
  output logic off_ls_o
);
  import ds_mon_pkg::*;

  logic [NSIDE-1:0] cmp_raw, cmp_s, gate, rise;
  logic [NSIDE-1:0] lat_next, lat, pulse, off_q;
  logic             blank;

  assign cmp_raw[SIDE_HS] = cmp_hs_i;
  assign cmp_raw[SIDE_LS] = cmp_ls_i;
  assign gate[SIDE_HS]    = gate_hs_i;
  assign gate[SIDE_LS]    = gate_ls_i;

  ds_sync #(.WIDTH(NSIDE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(cmp_raw), .q_o(cmp_s)
  );

  ds_blank_timer #(.NSIDE(NSIDE), .BLANK_CYCLES(BLANK_CYCLES)) u_blank (
    .clk(clk), .rst(rst), .gate_i(gate), .rise_o(rise), .blank_o(blank)
  );

  for (genvar i = 0; i < NSIDE; i++) begin : g_side
    ds_side_qual u_side (
      .clk(clk), .rst(rst), .cmp_s_i(cmp_s[i]), .gate_i(gate[i]),
      .rise_i(rise[i]), .blank_i(blank), .mask_i(mask_i),
      .sof_i(stop_on_fault_i), .lat_next_o(lat_next[i]),
      .lat_o(lat[i]), .pulse_o(pulse[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q <= '0;
    end else begin
      for (int i = 0; i < NSIDE; i++)
        off_q[i] <= lat_next[i] | (stop_on_fault_i & (|lat_next));
    end
  end

  assign flt_pulse_hs_o = pulse[SIDE_HS];
  assign flt_pulse_ls_o = pulse[SIDE_LS];
  assign flt_hs_o       = lat[SIDE_HS];
  assign flt_ls_o       = lat[SIDE_LS];
  assign off_hs_o       = off_q[SIDE_HS];
  assign off_ls_o       = off_q[SIDE_LS];

  p_sof_both_off_r4: assert property (@(posedge clk) disable iff (rst)
    (stop_on_fault_i && (|lat)) |=> (off_hs_o && off_ls_o));
  p_mask_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    mask_i |=> !(flt_pulse_hs_o || flt_pulse_ls_o));
  p_off_follows_latch_r1: assert property (@(posedge clk) disable iff (rst)
    flt_ls_o |-> off_ls_o);
  p_off_follows_latch_r2: assert property (@(posedge clk) disable iff (rst)
    flt_hs_o |-> off_hs_o);
endmodule

// File: tb/tb_ds_short_monitor.sv
module tb_ds_short_monitor;
  localparam int BLANK = 8;
  localparam int NVEC  = 9;
  // {sof,mask,ghs,gls,chs,cls, exp flt_hs,flt_ls,off_hs,off_ls, pulses_hs,pulses_ls}
  localparam logic [11:0] VEC [NVEC] = '{
    12'b0_0_0_1_0_1__0_1_0_1__0_1, // R1
    12'b0_0_1_0_1_0__1_0_1_0__1_0, // R2
    12'b1_0_0_1_0_1__0_1_1_1__0_1, // R4
    12'b1_0_1_0_1_0__1_0_1_1__1_0, // R4
    12'b0_1_0_1_0_1__0_0_0_0__0_0, // R6
    12'b1_1_1_0_1_0__0_0_0_0__0_0, // R6
    12'b0_0_1_0_0_1__0_0_0_0__0_0, // R9
    12'b0_0_0_0_1_1__0_0_0_0__0_0, // R9
    12'b0_0_0_1_0_0__0_0_0_0__0_0  // R1 idle
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cmp_hs = 0, cmp_ls = 0, g_hs = 0, g_ls = 0, sof = 0, mask = 0;
  logic p_hs, p_ls, f_hs, f_ls, o_hs, o_ls;
  int compared = 0, mismatched = 0;

  always #4 clk = ~clk;

  ds_short_monitor #(.BLANK_CYCLES(BLANK)) dut (
    .clk(clk), .rst(rst), .cmp_hs_i(cmp_hs), .cmp_ls_i(cmp_ls),
    .gate_hs_i(g_hs), .gate_ls_i(g_ls), .stop_on_fault_i(sof), .mask_i(mask),
    .flt_pulse_hs_o(p_hs), .flt_pulse_ls_o(p_ls), .flt_hs_o(f_hs),
    .flt_ls_o(f_ls), .off_hs_o(o_hs), .off_ls_o(o_ls)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int ph, pl;
    // R7: reset state
    do_reset();
    chk("R7 reset", {p_hs, p_ls, f_hs, f_ls, o_hs, o_ls}, 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      {sof, mask, g_hs, g_ls} = VEC[v][11:8];
      cmp_hs = 0; cmp_ls = 0;
      do_reset();
      repeat (BLANK + 4) @(negedge clk);
      {cmp_hs, cmp_ls} = VEC[v][7:6];
      ph = 0; pl = 0;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        ph += int'(p_hs); pl += int'(p_ls);
      end
      chk($sformatf("R1/R2/R4/R6/R9 vec%0d state", v),
          {f_hs, f_ls, o_hs, o_ls}, VEC[v][5:2]);
      chk($sformatf("R8 vec%0d pulses", v), ph * 2 + pl,
          int'(VEC[v][1]) * 2 + int'(VEC[v][0]));
    end

    // R8: latency of three edges, one-clock pulse
    sof = 0; mask = 0; g_hs = 0; g_ls = 1; cmp_hs = 0; cmp_ls = 0;
    do_reset();
    repeat (BLANK + 4) @(negedge clk);
    cmp_ls = 1;
    wait_neg(2);
    chk("R8 no output after 2 edges", {p_ls, f_ls, o_ls}, 0);
    wait_neg(1);
    chk("R8 output after 3rd edge", {p_ls, f_ls, o_ls}, 3'b111);
    wait_neg(1);
    chk("R8 pulse one clock", {p_ls, f_ls}, 2'b01);

    // R5: latch holds while off, clears on re-command, other side untouched
    g_ls = 0; cmp_ls = 0;
    wait_neg(4);
    chk("R5 hold while off", {f_ls, o_ls, o_hs}, 3'b110);
    g_ls = 1;
    wait_neg(1);
    chk("R5 cleared on re-command", {f_ls, o_ls}, 0);

    // R3: blanking window from gate rise with comparator already high
    g_ls = 0; cmp_ls = 1;
    do_reset();
    repeat (6) @(negedge clk);
    g_ls = 1;
    wait_neg(BLANK + 1);
    chk("R3 still blanked at E(B+1)", f_ls, 0);
    wait_neg(1);
    chk("R3 set at E(B+2)", f_ls, 1);

    // R4: stop-on-fault holds across re-commands until reset
    sof = 1; cmp_ls = 0; g_ls = 1;
    do_reset();
    repeat (BLANK + 4) @(negedge clk);
    cmp_hs = 1; g_hs = 1;
    repeat (BLANK + 6) @(negedge clk);
    chk("R4 hs latched both off", {f_hs, o_hs, o_ls}, 3'b111);
    cmp_hs = 0; g_hs = 0;
    repeat (3) @(negedge clk);
    g_hs = 1;
    wait_neg(2);
    chk("R4 hold after re-command", {f_hs, o_hs, o_ls}, 3'b111);
    do_reset();
    chk("R7 reset clears held fault", {f_hs, f_ls, o_hs, o_ls}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule